// File: doc/BRIEF.md
# Programmable Frequency Output Divider

This block produces a selectable square wave on an open-drain style interrupt pin. It runs from the 32768 Hz base clock. One free-running prescaler counter supplies four source rates: the base rate, base/32, base/1024 and base/32768. A small integer divider then divides the chosen source by one of eight ratios, and some of those ratios are odd. A host writes one 8-bit configuration byte. That byte holds an output enable, a 2-bit source code and a 3-bit ratio code.

The pin is modelled as an output-enable with a data value that is never anything but low. The low phase of the waveform is driven, and the high phase is represented by releasing the pin. When the output is disabled, or while either the alarm or the timer interrupt enable is set, the pin stays released (high impedance). Every write restarts both the prescaler and the divider, so a new setting begins at the start of a high phase.

Top module: `freq_out_div`

## Requirements
- R1: After reset the enable bit is 0 and the pin is released (`pin_oe` = 0).
- R2: A write captures the enable from bit 7, the source code from bits 4:3 and the ratio code from bits 2:0. Bits 6:5 are ignored, and a byte that differs only in those bits produces the same waveform.
- R3: Source code 00 selects the base clock, D = 1. Code 01 selects D = 2^SRC1_SHIFT (1024 Hz by default). Code 10 selects D = 2^SRC2_SHIFT (32 Hz). Code 11 selects D = 2^SRC3_SHIFT (1 Hz).
- R4: The ratio codes give these divisors: 000 = 1, 001 = 2, 010 = 3, 011 = 5, 100 = 6, 101 = 10, 110 = 15, 111 = 30.
- R5: While the output is active, the waveform period is P = N*D base cycles. In each period the pin is released for the first floor(P/2) cycles and driven low for the remaining cycles, so for an odd P the low phase is one cycle longer.
- R6: A write restarts the count. In the first cycle after the write edge the position is 0, and at the k-th cycle after it the position is k mod P.
- R7: While the enable bit is 0, the pin stays released for every source and ratio.
- R8: While `alarm_ie` or `timer_ie` is 1, the pin is released. The counters keep running during that time, so when both enables return to 0 the waveform continues at the phase it would have reached anyway.
- R9: `pin_dat` is always 0, so the block only ever pulls the pin low.
- R10: With base source and ratio 1, P = 1 and the high phase is empty, so an active output keeps the pin driven low continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Configuration byte: [7] enable, [4:3] source, [2:0] ratio |
| alarm_ie | input | 1 | Alarm interrupt enable; when set, forces the pin released |
| timer_ie | input | 1 | Timer interrupt enable; when set, forces the pin released |
| pin_oe | output | 1 | Pin output enable, 1 during the low phase |
| pin_dat | output | 1 | Pin data value, always 0 |

## Verification
The bench uses small prescaler shifts, so the full source and ratio space is swept: all 32 combinations with the enable set, each for more than two periods. Each combination's period and duty split are computed in the bench as N*D and floor(N*D/2). Odd products catch an off-by-one in the duty split, and the D = 1 column separates divider errors from prescaler errors. Repeated writes made mid-waveform show whether the restart takes effect. Further runs use a cleared enable, set reserved bits, and a raised alarm or timer enable in the middle of a period. These show that gating releases the pin without disturbing the phase count.

// File: rtl/fod_pkg.sv
package fod_pkg;

    typedef struct packed {
        logic       fe;
        logic [1:0] src;
        logic [2:0] ratio;
    } fod_cfg_t;

    localparam int unsigned DIV_W = 5;

    function automatic logic [DIV_W-1:0] ratio_of(input logic [2:0] code);
        logic [DIV_W-1:0] n;
        case (code)
            3'd0:    n = 5'd1;
            3'd1:    n = 5'd2;
            3'd2:    n = 5'd3;
            3'd3:    n = 5'd5;
            3'd4:    n = 5'd6;
            3'd5:    n = 5'd10;
            3'd6:    n = 5'd15;
            default: n = 5'd30;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fod_cfg_reg.sv
module fod_cfg_reg
    import fod_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [7:0]     wr_data,
    output fod_cfg_t       cfg,
    output logic           restart
);

    typedef struct packed {
        fod_cfg_t cfg;
    } cfg_state_t;

    cfg_state_t s_d, s_q;
    logic [1:0] unused_rsvd;

    assign unused_rsvd = wr_data[6:5];

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.cfg.fe    = wr_data[7];
            s_d.cfg.src   = wr_data[4:3];
            s_d.cfg.ratio = wr_data[2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg     = s_q.cfg;
    assign restart = wr_en;

endmodule

// File: rtl/fod_prescaler.sv
module fod_prescaler #(
    parameter int unsigned PRE_W = 15,
    parameter int unsigned SH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SH_W-1:0]  shift,
    output logic [PRE_W-1:0] pre_pos,
    output logic             tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask    = ~({PRE_W{1'b1}} << shift);
        pre_pos = s_q.cnt & mask;
        tick    = (pre_pos == mask);
        s_d     = s_q;
        if (restart) s_d.cnt = '0;
        else         s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/fod_divider.sv
module fod_divider #(
    parameter int unsigned PRE_W = 15,
    parameter int unsigned SH_W  = 4,
    parameter int unsigned DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [DIV_W-1:0] ratio_n,
    input  logic [SH_W-1:0]  shift,
    input  logic [PRE_W-1:0] pre_pos,
    output logic [DIV_W-1:0] div_cnt,
    output logic             low_phase
);

    localparam int unsigned POS_W = PRE_W + DIV_W;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] period;
    logic [POS_W-1:0] half;

    always_comb begin
        pos       = ({{PRE_W{1'b0}}, s_q.cnt} << shift) | {{DIV_W{1'b0}}, pre_pos};
        period    = {{PRE_W{1'b0}}, ratio_n} << shift;
        half      = period >> 1;
        low_phase = (pos >= half);

        s_d = s_q;
        if (restart) begin
            s_d.cnt = '0;
        end else if (tick) begin
            if (s_q.cnt == ratio_n - 1'b1) s_d.cnt = '0;
            else                           s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign div_cnt = s_q.cnt;

endmodule

// File: rtl/freq_out_div.sv
module freq_out_div
    import fod_pkg::*;
#(
    parameter int unsigned SRC1_SHIFT = 5,
    parameter int unsigned SRC2_SHIFT = 10,
    parameter int unsigned SRC3_SHIFT = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       alarm_ie,
    input  logic       timer_ie,
    output logic       pin_oe,
    output logic       pin_dat
);

    localparam int unsigned PRE_W = SRC3_SHIFT;
    localparam int unsigned SH_W  = $clog2(SRC3_SHIFT + 1);

    fod_cfg_t          cfg;
    logic              restart;
    logic [SH_W-1:0]   shift;
    logic [DIV_W-1:0]  ratio_n;
    logic [PRE_W-1:0]  pre_pos;
    logic              tick;
    logic [DIV_W-1:0]  div_cnt;
    logic              low_phase;
    logic              active;

    fod_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .restart (restart)
    );

    always_comb begin
        case (cfg.src)
            2'd0:    shift = '0;
            2'd1:    shift = SH_W'(SRC1_SHIFT);
            2'd2:    shift = SH_W'(SRC2_SHIFT);
            default: shift = SH_W'(SRC3_SHIFT);
        endcase
        ratio_n = ratio_of(cfg.ratio);
    end

    fod_prescaler #(.PRE_W(PRE_W), .SH_W(SH_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .shift   (shift),
        .pre_pos (pre_pos),
        .tick    (tick)
    );

    fod_divider #(.PRE_W(PRE_W), .SH_W(SH_W), .DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .tick      (tick),
        .ratio_n   (ratio_n),
        .shift     (shift),
        .pre_pos   (pre_pos),
        .div_cnt   (div_cnt),
        .low_phase (low_phase)
    );

    assign active  = cfg.fe & ~alarm_ie & ~timer_ie;
    assign pin_oe  = active & low_phase;
    assign pin_dat = 1'b0;

endmodule

// File: rtl/fod_checker.sv
module fod_checker #(
    parameter int unsigned PRE_W = 15,
    parameter int unsigned DIV_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             alarm_ie,
    input logic             timer_ie,
    input logic             pin_oe,
    input logic [PRE_W-1:0] pre_pos,
    input logic [DIV_W-1:0] div_cnt,
    input logic [DIV_W-1:0] ratio_n
);

    // R6: a write leaves both counters at position zero
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pre_pos == '0 && div_cnt == '0));

    // R5: divider count never reaches the selected divisor
    a_r5_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt < ratio_n);

    // R5: any setting other than base source with ratio 1 starts released
    a_r5_first_released: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[4:0] != 5'd0) |=> !pin_oe);

    // R7: writing a cleared enable releases the pin
    a_r7_fe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[7]) |=> !pin_oe);

    // R8: either interrupt enable forces release
    a_r8_ie_release: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_ie || timer_ie) |-> !pin_oe);

endmodule

bind freq_out_div fod_checker #(.PRE_W(PRE_W), .DIV_W(fod_pkg::DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .alarm_ie (alarm_ie),
    .timer_ie (timer_ie),
    .pin_oe   (pin_oe),
    .pre_pos  (pre_pos),
    .div_cnt  (div_cnt),
    .ratio_n  (ratio_n)
);

// File: tb/freq_out_div_test.sv
module freq_out_div_test;

    localparam int SH1 = 1;
    localparam int SH2 = 2;
    localparam int SH3 = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       alarm_ie = 1'b0;
    logic       timer_ie = 1'b0;
    logic       pin_oe;
    logic       pin_dat;

    int tests = 0;
    int failed = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    freq_out_div #(.SRC1_SHIFT(SH1), .SRC2_SHIFT(SH2), .SRC3_SHIFT(SH3)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .alarm_ie (alarm_ie),
        .timer_ie (timer_ie),
        .pin_oe   (pin_oe),
        .pin_dat  (pin_dat)
    );

    // R3 source divisor as a shift
    function automatic int sh_of(input int s);
        case (s)
            0: return 0;
            1: return SH1;
            2: return SH2;
            default: return SH3;
        endcase
    endfunction

    // R4 ratio table
    function automatic int n_of(input int c);
        case (c)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 5;
            4: return 6;
            5: return 10;
            6: return 15;
            default: return 30;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // ends at the falling edge after the write edge (position 0)
    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    // sample cycle k after a write; ie raised for k in [ie_from, ie_to)
    task automatic watch(input string tag, input int p, input bit act_en,
                         input int cycles, input int ie_from, input int ie_to,
                         input bit use_timer);
        int half;
        half = p / 2;
        for (int k = 0; k < cycles; k++) begin
            logic ie;
            logic exp;
            ie       = (k >= ie_from) && (k < ie_to);
            alarm_ie = ie && !use_timer;
            timer_ie = ie && use_timer;
            #1;
            exp = act_en && !ie && ((k % p) >= half);
            check(tag, pin_oe, exp);
            check("R9 pin data", pin_dat, 1'b0);
            @(negedge clk);
        end
        alarm_ie = 1'b0;
        timer_ie = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 oe in reset", pin_oe, 1'b0);
        check("R1 dat in reset", pin_dat, 1'b0);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R1 released after reset", pin_oe, 1'b0);
        end

        // R3 R4 R5 R6: full sweep with enable set, writes made mid-waveform
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 8; c++) begin
                int p;
                p = n_of(c) << sh_of(s);
                do_write(8'h80 | 8'(s << 3) | 8'(c));
                watch("R3 R4 R5 R6 sweep", p, 1'b1, 2 * p + 3, -1, -1, 1'b0);
            end
        end

        // R10 base source, ratio 1: continuously driven low
        do_write(8'h80);
        watch("R10 ratio one at base", 1, 1'b1, 12, -1, -1, 1'b0);

        // R7 enable cleared: released for every setting
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 8; c += 3) begin
                int p;
                p = n_of(c) << sh_of(s);
                do_write(8'(s << 3) | 8'(c));
                watch("R7 enable off", p, 1'b0, p + 2, -1, -1, 1'b0);
            end
        end

        // R2 reserved bits 6:5 set give the same waveform
        do_write(8'hE0 | 8'(1 << 3) | 8'd6);
        watch("R2 reserved bits", 15 << SH1, 1'b1, 2 * (15 << SH1), -1, -1, 1'b0);
        do_write(8'hA0 | 8'(3 << 3) | 8'd3);
        watch("R2 reserved bits", 5 << SH3, 1'b1, 2 * (5 << SH3), -1, -1, 1'b0);

        // R8 alarm enable mid-period, then timer enable; phase keeps running
        do_write(8'h80 | 8'(2 << 3) | 8'd4);
        watch("R8 alarm gate", 6 << SH2, 1'b1, 3 * (6 << SH2), 10, 20, 1'b0);
        do_write(8'h80 | 8'(1 << 3) | 8'd2);
        watch("R8 timer gate", 3 << SH1, 1'b1, 30, 4, 9, 1'b1);

        // R6 restart right after a previous write
        do_write(8'h80 | 8'd6);
        repeat (2) @(negedge clk);
        do_write(8'h80 | 8'd5);
        watch("R6 restart", 10, 1'b1, 25, -1, -1, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule